// File: doc/BRIEF.md
# Laser Output Safety Supervisor

This block decides whether a laser driver may source its bias and modulation currents. It watches a set of hard-fault comparator lines, each with its own mask bit, and a set of soft-warning lines. An unmasked hard fault that survives a short glitch filter is recorded and held. The latched fault output goes high and the current enable drops. A soft warning that survives the same filter is only recorded. It never touches the fault output or the enable.

The recorded state is sticky and is removed in one way only. The disable pin must be held high for a minimum time, a parameter given in microseconds and converted to clock cycles from the clock frequency. It is then released. A shorter pulse clears nothing. Any fault that is still present at the moment of release is recorded again at once. The power-on reset turns the currents off asynchronously and is released through a two-stage synchronizer.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While rst_n is low, drive_en_o, fault_o, hard_stat_o and soft_stat_o are all 0. After rst_n rises, the first two clock edges keep the block in reset, so drive_en_o can first go high after the second edge.
- R2: A fault or warning input counts as present only after it is sampled high on FILT_LEN consecutive rising edges (default 3). The matching status bit is set on the next edge. A pulse seen on fewer edges records nothing.
- R3: A hard fault whose bit in hard_mask_i is 1 on the latching edge is not recorded and does not raise fault_o.
- R4: An unmasked present hard fault sets bit i of hard_stat_o. fault_o is 1 exactly when hard_stat_o is nonzero. Both stay set after the input returns low.
- R5: A present soft warning sets bit i of soft_stat_o and has no effect on fault_o or drive_en_o.
- R6: If disable_i is sampled high on at least HOLD_US*CLK_MHZ consecutive edges (default 100) and then sampled low, both status vectors are cleared on that first low edge.
- R7: A disable_i high period shorter than that clears no status bit.
- R8: A hard fault or warning still present on the clearing edge remains set in its status vector.
- R9: drive_en_o is 1 exactly when the synchronized reset is released, tx_en_i is 1, disable_i is 0 and hard_stat_o is 0. It reacts to disable_i and tx_en_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| tx_en_i | input | 1 | Transmit enable control bit |
| disable_i | input | 1 | Disable pin, high turns currents off and arms the clear |
| hard_flt_i | input | NUM_HARD | Hard-fault comparator lines |
| hard_mask_i | input | NUM_HARD | Per-line hard-fault mask, 1 = ignore |
| soft_warn_i | input | NUM_SOFT | Soft-warning lines |
| drive_en_o | output | 1 | Enable for bias and modulation currents |
| fault_o | output | 1 | Latched fault indication |
| hard_stat_o | output | NUM_HARD | Recorded hard faults |
| soft_stat_o | output | NUM_SOFT | Recorded warnings |

## Verification
The bench drives single-line pulses of two cycles and of four or more cycles. These separate glitch rejection from a real latch. It also drives the same long pulse on a masked line, so masking is checked apart from filtering. Disable pulses of 50 and 120 cycles separate a too-short hold from a valid clear, and a clear while one fault line stays high shows re-latching. Soft-only activity with tx_en_i high shows that warnings never cut the current enable.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    CLR_IDLE  = 2'd0,
    CLR_COUNT = 2'd1,
    CLR_ARMED = 2'd2
  } clr_state_e;

  function automatic int unsigned hold_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction
endpackage

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/lsc_glitch_filter.sv
module lsc_glitch_filter #(
  parameter int unsigned WIDTH    = 4,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] filt_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [FILT_LEN-1:0] hist_q, hist_d;

    always_comb begin
      hist_d = {hist_q[FILT_LEN-2:0], din_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= hist_d;
    end

    assign filt_o[g] = &hist_q;

    // a qualified line must have been high on the previous sample
    assert_filter_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      filt_o[g] |-> $past(din_i[g]));
  end
endmodule

// File: rtl/lsc_clear_timer.sv
module lsc_clear_timer #(
  parameter int unsigned HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disable_i,
  output logic clr_o
);
  import lsc_pkg::*;
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  clr_state_e     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    clr_o  = 1'b0;
    unique case (st_q)
      CLR_IDLE: begin
        if (disable_i) begin
          st_d   = CLR_COUNT;
          cnt_d  = CW'(1);
          cnt_en = 1'b1;
        end
      end
      CLR_COUNT: begin
        if (!disable_i) begin
          st_d = CLR_IDLE;
        end else if (cnt_q == LAST) begin
          st_d = CLR_ARMED;
        end else begin
          cnt_d  = cnt_q + CW'(1);
          cnt_en = 1'b1;
        end
      end
      CLR_ARMED: begin
        if (!disable_i) begin
          st_d  = CLR_IDLE;
          clr_o = 1'b1;
        end
      end
      default: st_d = CLR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CLR_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // a clear is only issued on the release after a high period
  assert_clear_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> $past(disable_i));
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl #(
  parameter int unsigned NUM_HARD = 4,
  parameter int unsigned NUM_SOFT = 4,
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned CLK_MHZ  = 25,
  parameter int unsigned HOLD_US  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en_i,
  input  logic                disable_i,
  input  logic [NUM_HARD-1:0] hard_flt_i,
  input  logic [NUM_HARD-1:0] hard_mask_i,
  input  logic [NUM_SOFT-1:0] soft_warn_i,
  output logic                drive_en_o,
  output logic                fault_o,
  output logic [NUM_HARD-1:0] hard_stat_o,
  output logic [NUM_SOFT-1:0] soft_stat_o
);
  localparam int unsigned HOLD_CYC = lsc_pkg::hold_cycles(CLK_MHZ, HOLD_US);

  logic                rst_q_n;
  logic                clr;
  logic [NUM_HARD-1:0] hard_filt;
  logic [NUM_SOFT-1:0] soft_filt;
  logic [NUM_HARD-1:0] hard_stat_q, hard_stat_d;
  logic [NUM_SOFT-1:0] soft_stat_q, soft_stat_d;

  lsc_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  lsc_glitch_filter #(.WIDTH(NUM_HARD), .FILT_LEN(FILT_LEN)) i_hard_filt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .din_i  (hard_flt_i),
    .filt_o (hard_filt)
  );

  lsc_glitch_filter #(.WIDTH(NUM_SOFT), .FILT_LEN(FILT_LEN)) i_soft_filt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .din_i  (soft_warn_i),
    .filt_o (soft_filt)
  );

  lsc_clear_timer #(.HOLD_CYC(HOLD_CYC)) i_clear_timer (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .disable_i (disable_i),
    .clr_o     (clr)
  );

  // set wins over clear so a persisting fault re-latches on release
  always_comb begin
    hard_stat_d = (clr ? '0 : hard_stat_q) | (hard_filt & ~hard_mask_i);
    soft_stat_d = (clr ? '0 : soft_stat_q) | soft_filt;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hard_stat_q <= '0;
      soft_stat_q <= '0;
    end else begin
      hard_stat_q <= hard_stat_d;
      soft_stat_q <= soft_stat_d;
    end
  end

  assign hard_stat_o = hard_stat_q;
  assign soft_stat_o = soft_stat_q;
  assign fault_o     = |hard_stat_q;
  assign drive_en_o  = rst_q_n & tx_en_i & ~disable_i & ~fault_o;

  // newly set hard bits must have been unmasked on the latching edge
  assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hard_stat_q & ~$past(hard_stat_q) & $past(hard_mask_i)) == '0);

  // recorded hard faults survive until a clear
  assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fault_o && !clr) |=> fault_o);

  // after a clear only faults present at release remain
  assert_clear_result_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    clr |=> (hard_stat_q == $past(hard_filt & ~hard_mask_i)) &&
            (soft_stat_q == $past(soft_filt)));
endmodule

// File: tb/test_laser_safety_ctrl.sv
module test_laser_safety_ctrl;
  localparam int CLK_P = 10;
  localparam int NH    = 4;
  localparam int NS    = 4;
  localparam int FILT  = 3;
  localparam int HOLD  = 100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_en, dis;
  logic [NH-1:0] hflt, hmask;
  logic [NS-1:0] swarn;
  logic          drive_en, fault;
  logic [NH-1:0] hstat;
  logic [NS-1:0] sstat;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  laser_safety_ctrl i_laser_safety_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en),
    .disable_i   (dis),
    .hard_flt_i  (hflt),
    .hard_mask_i (hmask),
    .soft_warn_i (swarn),
    .drive_en_o  (drive_en),
    .fault_o     (fault),
    .hard_stat_o (hstat),
    .soft_stat_o (sstat)
  );

  // behavioural reference
  int      run_h[NH];
  int      run_s[NS];
  int      hcnt;
  bit      s1, s2;
  bit [NH-1:0] m_h;
  bit [NS-1:0] m_s;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; hcnt = 0; m_h = '0; m_s = '0;
      for (int i = 0; i < NH; i++) run_h[i] = 0;
      for (int i = 0; i < NS; i++) run_s[i] = 0;
    end else begin
      if (s2) begin
        bit clr_now;
        clr_now = !dis && (hcnt >= HOLD);
        if (clr_now) begin m_h = '0; m_s = '0; end
        for (int i = 0; i < NH; i++)
          if (run_h[i] >= FILT && !hmask[i]) m_h[i] = 1'b1;
        for (int i = 0; i < NS; i++)
          if (run_s[i] >= FILT) m_s[i] = 1'b1;
        hcnt = dis ? ((hcnt < HOLD) ? hcnt + 1 : HOLD) : 0;
        for (int i = 0; i < NH; i++) run_h[i] = hflt[i] ? ((run_h[i] < FILT) ? run_h[i] + 1 : FILT) : 0;
        for (int i = 0; i < NS; i++) run_s[i] = swarn[i] ? ((run_s[i] < FILT) ? run_s[i] + 1 : FILT) : 0;
      end
      s2 = s1;
      s1 = 1;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      bit exp_en;
      exp_en = s2 && tx_en && !dis && (m_h == '0);
      total++;
      if (hstat !== m_h || fault !== (m_h != '0) || sstat !== m_s || drive_en !== exp_en) begin
        bad++;
        $display("FAIL R4/R5/R9 cycle compare: hstat=%b fault=%b sstat=%b en=%b exp %b %b %b %b",
                 hstat, fault, sstat, drive_en, m_h, (m_h != '0), m_s, exp_en);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_seq(int hi);
    dis = 1'b1; cyc(hi);
    dis = 1'b0; cyc(1);
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b1; dis = 1'b0; hflt = '0; hmask = '0; swarn = '0;
    cyc(3);
    chk("R1 reset en", drive_en, 0);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset stat", {hstat, sstat}, 0);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_P/4);
    chk("R1 en after one edge", drive_en, 0);
    @(posedge clk); #(CLK_P/4);
    chk("R1 en after two edges", drive_en, 1);
    cyc(2);

    hflt[0] = 1'b1; cyc(2); hflt[0] = 1'b0; cyc(4);
    chk("R2 glitch rejected", hstat, 0);

    hflt[1] = 1'b1; cyc(4); hflt[1] = 1'b0; cyc(3);
    chk("R4 latched", hstat, 4'b0010);
    chk("R4 fault held", fault, 1);
    chk("R9 en off on fault", drive_en, 0);

    hmask[2] = 1'b1; hflt[2] = 1'b1; cyc(6); hflt[2] = 1'b0; cyc(2); hmask[2] = 1'b0;
    chk("R3 masked", hstat, 4'b0010);

    swarn[0] = 1'b1; cyc(5); swarn[0] = 1'b0; cyc(2);
    chk("R5 warn set", sstat, 4'b0001);

    clear_seq(50); cyc(2);
    chk("R7 short pulse", {hstat, sstat}, {4'b0010, 4'b0001});

    clear_seq(120); cyc(1);
    chk("R6 cleared", {hstat, sstat}, 0);
    chk("R9 en restored", drive_en, 1);

    swarn[2] = 1'b1; cyc(6);
    chk("R5 no kill", {drive_en, fault}, 2'b10);
    swarn[2] = 1'b0;

    hflt[3] = 1'b1; cyc(5);
    clear_seq(110); cyc(2);
    chk("R8 relatch", hstat, 4'b1000);
    hflt[3] = 1'b0; cyc(2);
    clear_seq(HOLD); cyc(1);
    chk("R6 exact hold", {hstat, sstat}, 0);

    dis = 1'b1; #1;
    chk("R9 disable kills", drive_en, 0);
    dis = 1'b0; tx_en = 1'b0; #1;
    chk("R9 tx_en low", drive_en, 0);
    tx_en = 1'b1; cyc(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule